// File: doc/BRIEF.md
# Pipelined Modular Adder Tree

This block adds N elements of a prime field and returns a single sum reduced modulo a fixed prime m. It is meant for the accumulation side of a vector-matrix product, where each row's products are summed into one field element. Operands are presented together as one flat word, one set per cycle. The reduced sum appears a fixed number of cycles later, and a valid flag travels alongside it.

The tree is built from two-input modular adders arranged in levels. Each level pairs neighbouring operands. When a level has an odd count, the unpaired operand passes through a delay line that matches the adder latency and joins the next level. Each adder reduces without a magnitude comparator. It forms the plain sum and the sum minus m, and the borrow of the subtraction picks between them. The element width, the operand count, the modulus and the adder pipeline depth are parameters. A depth of zero gives a purely combinational tree.

Top module: `modtree_top`

## Requirements
- R1: When every operand is below m, `sum_o` equals the sum of all N operands reduced modulo m. Operand i occupies bits [i*W +: W] of `in_ops`.
- R2: Whenever `out_valid` is high, `sum_o` is below m, including when every operand is close to m-1 and every node has to wrap.
- R3: A set whose plain sum is exactly m produces 0.
- R4: The latency is ceil(log2 N) times LAT cycles. `out_valid` is `in_valid` delayed by that same number of cycles.
- R5: A new operand set can be accepted on every cycle, with or without gaps in `in_valid`, and results leave in arrival order.
- R6: While `rst_n` is low, `out_valid` is low, and after release it stays low until the first accepted set emerges.
- R7: With LAT = 0, the sum is available combinationally in the same cycle as the operands.
- R8: Odd operand counts at any level are handled: every operand position, including those that bypass a level through the delay line, contributes to the sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the valid pipeline |
| in_valid | input | 1 | Marks `in_ops` as a set to be summed |
| in_ops | input | N*W | N operands, operand i at bits [i*W +: W] |
| out_valid | output | 1 | Marks `sum_o` as a result |
| sum_o | output | W | Sum of the operands modulo m |

## Verification
The assertions assume that every operand presented with `in_valid` is already below m; a dedicated check flags any violation of that assumption, because the nodes only correct a single overshoot. The stimulus keeps within this assumption by reducing wide random words modulo m and by building near-limit operands as m-1 minus a small offset. The zero-sum and latency properties follow a shadow copy of the input flags delayed by the pipeline depth.

// File: rtl/modtree_pkg.sv
package modtree_pkg;

    // Number of pairing levels needed to bring n operands down to one.
    function automatic int tree_levels(input int n);
        int c;
        int l;
        c = n;
        l = 0;
        while (c > 1) begin
            c = (c + 1) / 2;
            l++;
        end
        return l;
    endfunction

    // Operand count present at level lvl (level 0 = the inputs).
    function automatic int level_width(input int n, input int lvl);
        int c;
        c = n;
        for (int k = 0; k < lvl; k++) begin
            c = (c + 1) / 2;
        end
        return c;
    endfunction

endpackage

// File: rtl/mt_modadd.sv
module mt_modadd #(
    parameter int           W   = 255,
    parameter logic [W-1:0] MOD = '1,
    parameter int           LAT = 2
) (
    input  logic         clk,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] s
);
    localparam int XW = W + 2;

    logic [W:0]    raw;
    logic [XW-1:0] trial;
    logic [W-1:0]  red;

    // Two adders and a select: the borrow of (a+b-m) picks the result.
    always_comb begin
        raw   = {1'b0, a} + {1'b0, b};
        trial = {1'b0, raw} - {2'b00, MOD};
        // trial[W] is zero whenever the difference is chosen; folding it in
        // keeps every bit of the difference live without changing the value.
        red   = trial[XW-1] ? raw[W-1:0] : (trial[W-1:0] | {W{trial[W]}});
    end

    if (LAT == 0) begin : g_comb
        assign s = red;
    end else begin : g_pipe
        logic [W-1:0] st_d [LAT];
        logic [W-1:0] st_q [LAT];

        always_comb begin
            st_d[0] = red;
            for (int k = 1; k < LAT; k++) begin
                st_d[k] = st_q[k-1];
            end
        end

        always_ff @(posedge clk) begin
            st_q <= st_d;
        end

        assign s = st_q[LAT-1];
    end

endmodule

// File: rtl/mt_delay.sv
module mt_delay #(
    parameter int W   = 255,
    parameter int LAT = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    if (LAT == 0) begin : g_wire
        assign q = d;
    end else begin : g_regs
        logic [W-1:0] dl_d [LAT];
        logic [W-1:0] dl_q [LAT];

        always_comb begin
            dl_d[0] = d;
            for (int k = 1; k < LAT; k++) begin
                dl_d[k] = dl_q[k-1];
            end
        end

        always_ff @(posedge clk) begin
            dl_q <= dl_d;
        end

        assign q = dl_q[LAT-1];
    end

endmodule

// File: rtl/modtree_top.sv
module modtree_top #(
    parameter int           W   = 255,
    parameter int           N   = 12,
    parameter logic [W-1:0] MOD = 255'h73eda753299d7d483339d80809a1d80553bda402fffe5bfeffffffff00000001,
    parameter int           LAT = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [N*W-1:0] in_ops,
    output logic           out_valid,
    output logic [W-1:0]   sum_o
);
    localparam int NLEV  = modtree_pkg::tree_levels(N);
    localparam int TOTAL = NLEV * LAT;

    // ---------------- data tree ----------------
    for (genvar l = 0; l <= NLEV; l++) begin : g_lvl
        localparam int CNT = modtree_pkg::level_width(N, l);
        logic [W-1:0] e [CNT];

        if (l == 0) begin : g_in
            for (genvar i = 0; i < CNT; i++) begin : g_el
                assign e[i] = in_ops[i*W +: W];
            end
        end else begin : g_red
            localparam int PREV = modtree_pkg::level_width(N, l - 1);

            for (genvar p = 0; p < PREV / 2; p++) begin : g_pair
                mt_modadd #(.W(W), .MOD(MOD), .LAT(LAT)) u_add (
                    .clk (clk),
                    .a   (g_lvl[l-1].e[2*p]),
                    .b   (g_lvl[l-1].e[2*p+1]),
                    .s   (e[p])
                );
            end

            if (PREV % 2 == 1) begin : g_odd
                mt_delay #(.W(W), .LAT(LAT)) u_skip (
                    .clk (clk),
                    .d   (g_lvl[l-1].e[PREV-1]),
                    .q   (e[CNT-1])
                );
            end
        end
    end

    assign sum_o = g_lvl[NLEV].e[0];

    // ---------------- valid flag ----------------
    if (TOTAL == 0) begin : g_vcomb
        assign out_valid = in_valid;
    end else begin : g_vpipe
        logic [TOTAL-1:0] vld_d;
        logic [TOTAL-1:0] vld_q;

        always_comb begin
            vld_d = (vld_q << 1) | TOTAL'(in_valid);
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) vld_q <= '0;
            else        vld_q <= vld_d;
        end

        assign out_valid = vld_q[TOTAL-1];
    end

endmodule

// File: rtl/modtree_chk.sv
module modtree_chk #(
    parameter int           W     = 255,
    parameter int           N     = 12,
    parameter logic [W-1:0] MOD   = '1,
    parameter int           TOTAL = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic [N*W-1:0] in_ops,
    input logic           out_valid,
    input logic [W-1:0]   sum_o
);
    logic sh_v [TOTAL+1];
    logic sh_z [TOTAL+1];

    assign sh_v[0] = in_valid;
    assign sh_z[0] = in_valid && (in_ops == '0);

    for (genvar k = 1; k <= TOTAL; k++) begin : g_sh
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sh_v[k] <= 1'b0;
                sh_z[k] <= 1'b0;
            end else begin
                sh_v[k] <= sh_v[k-1];
                sh_z[k] <= sh_z[k-1];
            end
        end
    end

    // Input assumption behind R1: every operand is already reduced.
    always @(posedge clk) begin
        if (rst_n && in_valid) begin
            for (int i = 0; i < N; i++) begin
                p_in_range_r1: assert (in_ops[i*W +: W] < MOD)
                    else $error("operand %0d not below modulus", i);
            end
        end
    end

    p_out_below_mod_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (sum_o < MOD));

    p_valid_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == sh_v[TOTAL]);

    p_zero_in_zero_out_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sh_z[TOTAL] |-> (sum_o == '0));

    if (TOTAL > 0) begin : g_rst
        p_reset_quiet_r6: assert property (@(posedge clk)
            !rst_n |-> !out_valid);
    end

endmodule

bind modtree_top modtree_chk #(.W(W), .N(N), .MOD(MOD), .TOTAL(TOTAL)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ops    (in_ops),
    .out_valid (out_valid),
    .sum_o     (sum_o)
);

// File: tb/modtree_top_test.sv
`timescale 1ns/1ps
module modtree_top_test;
    localparam int           W     = 255;
    localparam int           N     = 12;
    localparam int           NC    = 5;
    localparam int           LAT   = 2;
    localparam logic [W-1:0] MOD   = 255'h73eda753299d7d483339d80809a1d80553bda402fffe5bfeffffffff00000001;
    localparam int           DEPTH = $clog2(N) * LAT;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           in_valid;
    logic [N*W-1:0] in_ops;
    logic           out_valid, c_valid;
    logic [W-1:0]   sum_o, c_sum;

    always #2 clk = ~clk;

    modtree_top #(.W(W), .N(N), .MOD(MOD), .LAT(LAT)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ops(in_ops),
        .out_valid(out_valid), .sum_o(sum_o));

    modtree_top #(.W(W), .N(NC), .MOD(MOD), .LAT(0)) uut_c (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ops(in_ops[NC*W-1:0]),
        .out_valid(c_valid), .sum_o(c_sum));

    typedef struct {
        bit           v;
        logic [W-1:0] s;
        string        tag;
    } exp_t;

    exp_t         q[$];
    logic [W-1:0] opv [N];
    int           n_cmp = 0;
    int           n_bad = 0;

    function automatic logic [W-1:0] ref_sum(input int cnt);
        logic [W+7:0] acc;
        acc = '0;
        for (int i = 0; i < cnt; i++) acc = acc + {8'h00, opv[i]};
        return W'(acc % {8'h00, MOD});
    endfunction

    function automatic logic [W-1:0] rnd_el();
        logic [255:0] r;
        r = {$urandom, $urandom, $urandom, $urandom,
             $urandom, $urandom, $urandom, $urandom};
        return W'(r % {1'b0, MOD});
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    // One cycle: drive a set at the falling edge, model it, compare outputs.
    task automatic cycle(input bit v, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = v;
        for (int i = 0; i < N; i++) in_ops[i*W +: W] = opv[i];
        q.push_back('{v: v, s: ref_sum(N), tag: tag});
        #1;
        check("R7 comb", c_sum, ref_sum(NC));
        if (q.size() > DEPTH) begin
            e = q.pop_front();
            check("R4 valid", W'(out_valid), W'(e.v));
            if (e.v) check(e.tag, sum_o, e.s);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_ops   = '0;
        for (int i = 0; i < N; i++) opv[i] = '0;

        // R6: quiet during reset
        repeat (4) begin
            @(negedge clk);
            check("R6 reset", W'(out_valid), '0);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1: random back-to-back sets
        repeat (40) begin
            for (int i = 0; i < N; i++) opv[i] = rnd_el();
            cycle(1'b1, "R1 random");
        end

        // R1: all zero
        for (int i = 0; i < N; i++) opv[i] = '0;
        cycle(1'b1, "R1 zero");

        // R2: every operand near m-1
        repeat (20) begin
            for (int i = 0; i < N; i++) opv[i] = MOD - 1 - W'($urandom_range(0, 3));
            cycle(1'b1, "R2 near-limit");
        end
        for (int i = 0; i < N; i++) opv[i] = MOD - 1;
        cycle(1'b1, "R2 all m-1");

        // R3: plain sum exactly m, through a paired node and through the skip path
        for (int i = 0; i < N; i++) opv[i] = '0;
        opv[0] = MOD - 1; opv[1] = 1;
        cycle(1'b1, "R3 pair");
        for (int i = 0; i < N; i++) opv[i] = '0;
        opv[0] = MOD - 1; opv[N-1] = 1;
        cycle(1'b1, "R3 skip");

        // R8: each position alone, including those routed through delay lines
        for (int k = 0; k < N; k++) begin
            for (int i = 0; i < N; i++) opv[i] = '0;
            opv[k] = rnd_el();
            cycle(1'b1, "R8 position");
        end

        // R5: gapped valid, results in order
        repeat (40) begin
            for (int i = 0; i < N; i++) opv[i] = rnd_el();
            cycle(1'($urandom_range(0, 1)), "R5 gapped");
        end

        // drain
        repeat (DEPTH + 2) cycle(1'b0, "R5 drain");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule